// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block reads a program from a byte-wide ROM, one byte per clock, and assembles each instruction for an execute stage. Every instruction starts with a 16-bit opcode word, stored as two bytes with the high byte first. Zero to four extension bytes may follow. Their number depends on the opcode class and on the two-bit source-mode field of the word. Once the last byte of an instruction is in, the block shows the decoded fields, the immediate byte and up to two 16-bit addresses with `valid_o` high. It holds them there until the execute stage raises `advance_i`.

The block also resolves conditional jumps, using carry, zero and sign flags that come from outside. A taken jump reloads the program counter with the fetched target. A jump that is not taken carries on at the byte after the target address. A HALT instruction that has been accepted stops all fetching until reset. The ROM is read combinationally: `rom_data_i` must reflect `rom_addr_o` within the same cycle.

Top module: `ifetch_seq`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), `rom_addr_o` is 0 and `valid_o` and `halted_o` are 0. After release, the first byte fetched is at address 0.
- R2: Byte 0 of an instruction is bits [15:8] of the opcode word and byte 1 is bits [7:0]. While `valid_o` is high: `opcode_o` = [15:11], `mode_o` = [10:9], `reg_a_o` = [7:5], `reg_b_o` = [4:2] and `cond_o` = [1:0].
- R3: The opcode classes are as follows. Any opcode with bit 4 clear is ALU (class 0). 5'h12 is LOAD (1), 5'h13 is STORE (2), 5'h14 is MOVE (3), 5'h15 is JUMP (4) and 5'h11 is HALT (6). Every other opcode is NOP (5). `class_o` gives the class while `valid_o` is high.
- R4: The total length in bytes depends on the class and mode. An ALU instruction is 3 bytes in mode 2'b10 (immediate) and 2 otherwise. A LOAD is 3 bytes in mode 2'b10, 4 in mode 2'b01 (memory) and 2 otherwise. STORE and JUMP are 4 bytes, MOVE is 6 bytes, and NOP and HALT are 2.
- R5: `imm_o` is byte 2. `addr_a_o` is bytes 2 and 3, high byte first. `addr_b_o` is bytes 4 and 5, high byte first. Bytes that lie beyond the current instruction's length read as 0, even when an earlier instruction was longer.
- R6: `rom_rd_o` is high for exactly one cycle per byte. `rom_addr_o` rises by one after each fetched byte. When `valid_o` rises, `rom_addr_o` points at the byte after the instruction.
- R7: `valid_o` stays high, with all outputs stable and no fetch, until `advance_i` is seen high. Fetching of the next instruction then starts in the following cycle.
- R8: For a JUMP, `taken_o` is high while `valid_o` is high and the condition holds. The conditions are: cond 2'b00 always, 2'b01 when carry is set, 2'b10 when zero is set, and 2'b11 when negative is set. On accept, a taken jump moves `rom_addr_o` to `addr_a_o`. A jump that is not taken leaves `rom_addr_o` at the byte after the target.
- R9: Once a HALT has been accepted, `halted_o` is 1 and `valid_o` and `rom_rd_o` stay 0 until reset.
- R10: The program counter wraps from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rom_rd_o | output | 1 | A byte is being fetched this cycle |
| rom_addr_o | output | 16 | Program counter / ROM byte address |
| rom_data_i | input | 8 | ROM byte at `rom_addr_o`, same cycle |
| advance_i | input | 1 | Execute stage accepts the presented instruction |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative (sign) flag |
| valid_o | output | 1 | A complete instruction is presented |
| class_o | output | 3 | Instruction class code |
| opcode_o | output | 5 | Opcode field |
| mode_o | output | 2 | Source-mode field |
| reg_a_o | output | 3 | Register field [7:5] |
| reg_b_o | output | 3 | Register field [4:2] |
| cond_o | output | 2 | Jump condition field |
| imm_o | output | 8 | Immediate byte |
| addr_a_o | output | 16 | First address (source or jump target) |
| addr_b_o | output | 16 | Second address (MOVE destination) |
| taken_o | output | 1 | Presented jump will be taken |
| halted_o | output | 1 | Fetching stopped by HALT |

## Verification
The bench builds the block with its default opcode values, so the 32 opcodes fall into seven classes. A sweep over all 32 opcodes and all four mode values reaches every length and class, including the unassigned codes and the reserved mode 2'b11. The bench's ROM is 256 bytes and is mirrored across the 16-bit space. This lets a jump to 16'hFFFE reach the address wrap. The bench also sweeps all four conditions against all eight flag combinations, and it runs a long-then-short instruction pair to check that stale extension bytes are cleared.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int OPC_W   = 5;
  localparam int MAX_LEN = 6;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  localparam logic [1:0] MODE_REG = 2'b00;
  localparam logic [1:0] MODE_MEM = 2'b01;
  localparam logic [1:0] MODE_IMM = 2'b10;

  typedef enum logic [2:0] {
    CLS_ALU   = 3'd0,
    CLS_LOAD  = 3'd1,
    CLS_STORE = 3'd2,
    CLS_MOVE  = 3'd3,
    CLS_JUMP  = 3'd4,
    CLS_NOP   = 3'd5,
    CLS_HALT  = 3'd6
  } cls_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_READY = 2'd1,
    ST_HALT  = 2'd2
  } st_e;
endpackage

// File: rtl/ifs_classify.sv
module ifs_classify
  import ifs_pkg::*;
#(
  parameter logic [OPC_W-1:0] OP_HALT  = 5'h11,
  parameter logic [OPC_W-1:0] OP_LOAD  = 5'h12,
  parameter logic [OPC_W-1:0] OP_STORE = 5'h13,
  parameter logic [OPC_W-1:0] OP_MOVE  = 5'h14,
  parameter logic [OPC_W-1:0] OP_JUMP  = 5'h15
) (
  input  logic [OPC_W-1:0] opc_i,
  input  logic [1:0]       mode_i,
  output cls_e             cls_o,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    if (!opc_i[OPC_W-1])      cls_o = CLS_ALU;
    else if (opc_i == OP_LOAD)  cls_o = CLS_LOAD;
    else if (opc_i == OP_STORE) cls_o = CLS_STORE;
    else if (opc_i == OP_MOVE)  cls_o = CLS_MOVE;
    else if (opc_i == OP_JUMP)  cls_o = CLS_JUMP;
    else if (opc_i == OP_HALT)  cls_o = CLS_HALT;
    else                        cls_o = CLS_NOP;
  end

  always_comb begin
    unique case (cls_o)
      CLS_ALU:   len_o = (mode_i == MODE_IMM) ? LEN_W'(3) : LEN_W'(2);
      CLS_LOAD:  len_o = (mode_i == MODE_IMM) ? LEN_W'(3) :
                         (mode_i == MODE_MEM) ? LEN_W'(4) : LEN_W'(2);
      CLS_STORE: len_o = LEN_W'(4);
      CLS_MOVE:  len_o = LEN_W'(MAX_LEN);
      CLS_JUMP:  len_o = LEN_W'(4);
      default:   len_o = LEN_W'(2);
    endcase
  end
endmodule

// File: rtl/ifs_cond.sv
module ifs_cond (
  input  logic [1:0] cond_i,
  input  logic       c_i,
  input  logic       z_i,
  input  logic       n_i,
  output logic       hit_o
);
  always_comb begin
    unique case (cond_i)
      2'b00: hit_o = 1'b1;
      2'b01: hit_o = c_i;
      2'b10: hit_o = z_i;
      default: hit_o = n_i;
    endcase
  end
endmodule

// File: rtl/ifs_bytebuf.sv
module ifs_bytebuf
  import ifs_pkg::*;
#(
  parameter int NB = MAX_LEN,
  localparam int IW = $clog2(NB)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [IW-1:0]                idx_i,
  input  logic [BYTE_W-1:0]            byte_i,
  output logic [NB-1:0][BYTE_W-1:0]    bytes_o
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_o[g] <= '0;
      end else if (wr_i) begin
        if (idx_i == IW'(g))   bytes_o[g] <= byte_i;
        else if (idx_i == '0)  bytes_o[g] <= '0;  // new instruction: drop stale bytes
      end
    end
  end
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifs_pkg::*;
#(
  parameter logic [4:0] OP_HALT  = 5'h11,
  parameter logic [4:0] OP_LOAD  = 5'h12,
  parameter logic [4:0] OP_STORE = 5'h13,
  parameter logic [4:0] OP_MOVE  = 5'h14,
  parameter logic [4:0] OP_JUMP  = 5'h15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        rom_rd_o,
  output logic [15:0] rom_addr_o,
  input  logic [7:0]  rom_data_i,
  input  logic        advance_i,
  input  logic        flag_c_i,
  input  logic        flag_z_i,
  input  logic        flag_n_i,
  output logic        valid_o,
  output logic [2:0]  class_o,
  output logic [4:0]  opcode_o,
  output logic [1:0]  mode_o,
  output logic [2:0]  reg_a_o,
  output logic [2:0]  reg_b_o,
  output logic [1:0]  cond_o,
  output logic [7:0]  imm_o,
  output logic [15:0] addr_a_o,
  output logic [15:0] addr_b_o,
  output logic        taken_o,
  output logic        halted_o
);
  localparam int IW = $clog2(MAX_LEN);

  st_e                            state_q;
  logic [WORD_W-1:0]              pc_q;
  logic [IW-1:0]                  idx_q;
  logic [LEN_W-1:0]               len_q;
  cls_e                           cls_q;
  logic [MAX_LEN-1:0][BYTE_W-1:0] buf_w;
  cls_e                           cls_w;
  logic [LEN_W-1:0]               len_w;
  logic                           fetch_w, last_w, accept_w, hit_w;
  logic                           unused_bit;

  assign fetch_w  = (state_q == ST_FETCH);
  assign accept_w = (state_q == ST_READY) && advance_i;

  ifs_bytebuf #(.NB(MAX_LEN)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (fetch_w),
    .idx_i   (idx_q),
    .byte_i  (rom_data_i),
    .bytes_o (buf_w)
  );

  // class and length are fixed once the high opcode byte is held
  ifs_classify #(
    .OP_HALT(OP_HALT), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_MOVE(OP_MOVE), .OP_JUMP(OP_JUMP)
  ) u_cls (
    .opc_i  (buf_w[0][7:3]),
    .mode_i (buf_w[0][2:1]),
    .cls_o  (cls_w),
    .len_o  (len_w)
  );

  ifs_cond u_cond (
    .cond_i (buf_w[1][1:0]),
    .c_i    (flag_c_i),
    .z_i    (flag_z_i),
    .n_i    (flag_n_i),
    .hit_o  (hit_w)
  );

  always_comb begin
    last_w = 1'b0;
    if (fetch_w) begin
      if (idx_q == IW'(1))      last_w = (len_w == LEN_W'(2));
      else if (idx_q >= IW'(2)) last_w = (LEN_W'(idx_q) == LEN_W'(len_q - LEN_W'(1)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      idx_q   <= '0;
      len_q   <= LEN_W'(2);
      cls_q   <= CLS_NOP;
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          pc_q  <= pc_q + 1'b1;
          idx_q <= idx_q + 1'b1;
          if (idx_q == IW'(1)) begin
            len_q <= len_w;
            cls_q <= cls_w;
          end
          if (last_w) begin
            state_q <= ST_READY;
            idx_q   <= '0;
          end
        end
        ST_READY: begin
          if (advance_i) begin
            state_q <= (cls_q == CLS_HALT) ? ST_HALT : ST_FETCH;
            if (taken_o) pc_q <= addr_a_o;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign rom_rd_o   = fetch_w;
  assign rom_addr_o = pc_q;
  assign valid_o    = (state_q == ST_READY);
  assign halted_o   = (state_q == ST_HALT);
  assign class_o    = cls_q;
  assign opcode_o   = buf_w[0][7:3];
  assign mode_o     = buf_w[0][2:1];
  assign reg_a_o    = buf_w[1][7:5];
  assign reg_b_o    = buf_w[1][4:2];
  assign cond_o     = buf_w[1][1:0];
  assign imm_o      = buf_w[2];
  assign addr_a_o   = {buf_w[2], buf_w[3]};
  assign addr_b_o   = {buf_w[4], buf_w[5]};
  assign taken_o    = valid_o && (cls_q == CLS_JUMP) && hit_w;
  assign unused_bit = buf_w[0][0] ^ accept_w;
endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rom_rd_o,
  input logic [15:0] rom_addr_o,
  input logic        advance_i,
  input logic        valid_o,
  input logic [4:0]  opcode_o,
  input logic [15:0] addr_a_o,
  input logic [15:0] addr_b_o,
  input logic        taken_o,
  input logic        halted_o
);
  // R1: reset state at every edge seen during reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r1: assert (rom_addr_o == 16'h0 && !valid_o && !halted_o)
        else $error("reset state wrong");
    end
  end

  // R6: every fetched byte advances the address by one (wrapping, R10)
  p_pc_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_rd_o |=> rom_addr_o == 16'($past(rom_addr_o) + 16'd1));

  // R7: no fetch while an instruction is presented
  p_no_fetch_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !rom_rd_o);

  // R7: presented instruction holds until accepted
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !advance_i |=> valid_o && $stable(opcode_o) && $stable(addr_a_o)
                              && $stable(addr_b_o) && $stable(rom_addr_o));

  // R8: taken jump redirects to the target
  p_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && advance_i && taken_o |=> rom_addr_o == $past(addr_a_o));

  // R9: halt is sticky and silent
  p_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && !rom_rd_o && !valid_o);
endmodule

bind ifetch_seq ifetch_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rom_rd_o   (rom_rd_o),
  .rom_addr_o (rom_addr_o),
  .advance_i  (advance_i),
  .valid_o    (valid_o),
  .opcode_o   (opcode_o),
  .addr_a_o   (addr_a_o),
  .addr_b_o   (addr_b_o),
  .taken_o    (taken_o),
  .halted_o   (halted_o)
);

// File: tb/sim_ifetch_seq.sv
module sim_ifetch_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] OPN = 5'h10, OPH = 5'h11, OPL = 5'h12,
                         OPS = 5'h13, OPM = 5'h14, OPJ = 5'h15;

  logic        clk = 1'b0, rst_ni = 1'b0, advance_i = 1'b0;
  logic        flag_c_i = 1'b0, flag_z_i = 1'b0, flag_n_i = 1'b0;
  logic        rom_rd_o, valid_o, taken_o, halted_o;
  logic [15:0] rom_addr_o, addr_a_o, addr_b_o;
  logic [7:0]  rom_data_i, imm_o;
  logic [2:0]  class_o, reg_a_o, reg_b_o;
  logic [4:0]  opcode_o;
  logic [1:0]  mode_o, cond_o;
  logic [7:0]  rom [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rom_data_i = rom[rom_addr_o[7:0]];

  ifetch_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_data_i), .advance_i(advance_i), .flag_c_i(flag_c_i),
    .flag_z_i(flag_z_i), .flag_n_i(flag_n_i), .valid_o(valid_o), .class_o(class_o),
    .opcode_o(opcode_o), .mode_o(mode_o), .reg_a_o(reg_a_o), .reg_b_o(reg_b_o),
    .cond_o(cond_o), .imm_o(imm_o), .addr_a_o(addr_a_o), .addr_b_o(addr_b_o),
    .taken_o(taken_o), .halted_o(halted_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [4:0] op, input logic [1:0] md);
    if (!op[4])    return (md == 2'b10) ? 3 : 2;
    if (op == OPL) return (md == 2'b10) ? 3 : (md == 2'b01) ? 4 : 2;
    if (op == OPS || op == OPJ) return 4;
    if (op == OPM) return 6;
    return 2;
  endfunction

  function automatic logic [2:0] exp_cls(input logic [4:0] op);
    if (!op[4])    return 3'd0;
    if (op == OPL) return 3'd1;
    if (op == OPS) return 3'd2;
    if (op == OPM) return 3'd3;
    if (op == OPJ) return 3'd4;
    if (op == OPH) return 3'd6;
    return 3'd5;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_valid(output int n);
    int guard = 0;
    n = 0;
    while (!valid_o && guard < 40) begin
      if (rom_rd_o) n++;
      @(negedge clk);
      guard++;
    end
    if (!valid_o) chk("R7 valid never rose", 0, 1);
  endtask

  task automatic accept();
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) rom[i] = 8'hEE;

    // R1 reset state
    @(negedge clk);
    chk("R1 addr in reset", rom_addr_o, 16'h0);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 halted in reset", halted_o, 0);

    // R2..R6 sweep over every opcode and mode
    for (int op = 0; op < 32; op++) begin
      for (int md = 0; md < 4; md++) begin
        logic [2:0] ra, rb;
        int ln;
        ra = 3'(op + md);
        rb = 3'(op * 3 + md);
        rom[0] = {5'(op), 2'(md), 1'b0};
        rom[1] = {ra, rb, 2'(md)};
        rom[2] = 8'hC1; rom[3] = 8'h37; rom[4] = 8'h9E; rom[5] = 8'h42;
        do_reset();
        wait_valid(n);
        ln = exp_len(5'(op), 2'(md));
        chk("R4 length", n, ln);
        chk("R6 pc after instr", rom_addr_o, 16'(ln));
        chk("R3 class", class_o, exp_cls(5'(op)));
        chk("R2 fields", {opcode_o, mode_o, reg_a_o, reg_b_o, cond_o},
            {5'(op), 2'(md), ra, rb, 2'(md)});
        chk("R5 imm", imm_o, (ln >= 3) ? 8'hC1 : 8'h00);
        chk("R5 addr_a", addr_a_o, {(ln >= 3) ? 8'hC1 : 8'h00, (ln >= 4) ? 8'h37 : 8'h00});
        chk("R5 addr_b", addr_b_o, (ln >= 6) ? 16'h9E42 : 16'h0000);
      end
    end

    // R7 hold, then R5 stale-byte clearing: MOVE then ALU immediate
    rom[0] = {OPM, 2'b01, 1'b0}; rom[1] = 8'h00;
    rom[2] = 8'h12; rom[3] = 8'h34; rom[4] = 8'h56; rom[5] = 8'h78;
    rom[6] = {5'h03, 2'b10, 1'b0}; rom[7] = 8'h24; rom[8] = 8'hA5;
    do_reset();
    wait_valid(n);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 valid held", valid_o, 1);
      chk("R7 no fetch while held", rom_rd_o, 0);
      chk("R7 addr held", {addr_a_o, addr_b_o}, 32'h12345678);
    end
    accept();
    chk("R7 fetch resumes", {valid_o, rom_rd_o}, 2'b01);
    wait_valid(n);
    chk("R4 second instr length", n, 3);
    chk("R5 stale addr_b cleared", addr_b_o, 16'h0);
    chk("R5 addr_a short instr", addr_a_o, 16'hA500);
    chk("R6 pc second instr", rom_addr_o, 16'd9);

    // R8 every condition against every flag set
    for (int cd = 0; cd < 4; cd++) begin
      for (int fl = 0; fl < 8; fl++) begin
        bit tk;
        rom[0] = {OPJ, 3'b000}; rom[1] = {6'b0, 2'(cd)};
        rom[2] = 8'h00; rom[3] = 8'h40;
        do_reset();
        wait_valid(n);
        {flag_c_i, flag_z_i, flag_n_i} = 3'(fl);
        tk = (cd == 0) || (cd == 1 && fl[2]) || (cd == 2 && fl[1]) || (cd == 3 && fl[0]);
        #1;
        chk("R8 taken flag", taken_o, tk);
        accept();
        chk("R8 next address", rom_addr_o, tk ? 16'h0040 : 16'h0004);
      end
    end
    {flag_c_i, flag_z_i, flag_n_i} = 3'b000;

    // R10 wrap past the top of the address space
    rom[0] = {OPJ, 3'b000}; rom[1] = 8'h00; rom[2] = 8'hFF; rom[3] = 8'hFE;
    rom[8'hFE] = {OPN, 3'b000}; rom[8'hFF] = 8'h00;
    do_reset();
    wait_valid(n);
    accept();
    chk("R10 jump to top", rom_addr_o, 16'hFFFE);
    wait_valid(n);
    chk("R10 wrapped address", rom_addr_o, 16'h0000);
    chk("R3 nop class at top", class_o, 3'd5);

    // R9 halt
    rom[0] = {OPH, 3'b000}; rom[1] = 8'h00; rom[2] = {OPN, 3'b000}; rom[3] = 8'h00;
    do_reset();
    wait_valid(n);
    chk("R9 not halted before accept", halted_o, 0);
    chk("R3 halt class", class_o, 3'd6);
    accept();
    for (int k = 0; k < 10; k++) begin
      chk("R9 halted and silent", {halted_o, valid_o, rom_rd_o}, 3'b100);
      chk("R9 address frozen", rom_addr_o, 16'd2);
      @(negedge clk);
    end
    do_reset();
    chk("R1 restart after reset", {halted_o, rom_rd_o, rom_addr_o}, {2'b01, 16'h0});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule